// File: doc/BRIEF.md
# Write-Once Flash Timing Divider

This block turns a fast oscillator clock into a slow periodic tick, used to pace the timed steps of flash program and erase sequences. Software sets it up once through a single 8-bit configuration register at offset zero of a small byte-wide bus. The register has three fields: a divide-by-8 prescaler enable, a 6-bit divider value, and a read-only flag that records whether the register has been written.

The first write to offset zero after reset fixes the prescaler and divider settings. Later writes change nothing. Until that first write, the tick output stays low, so no timed operation can start with an unconfigured divider. Software is expected to pick a setting that brings the tick into a 150 kHz to 200 kHz window.

Two small state machines form the core:
- The configuration machine moves from `CFG_BLANK` to `CFG_LOCKED` on the first write to offset zero. Reset is the only way back.
- The tick machine moves from `TK_IDLE` to `TK_RUN` once the configuration is locked. It stays in `TK_RUN` until reset.

In `TK_RUN`, the down-counter reloads from the divider field each time it reaches zero.

Top module: `flash_tick_div`

## Requirements
- R1: Reading offset zero returns the whole register: bit 7 is the written flag, bit 6 is the prescaler enable, and bits 5:0 are the divider value.
- R2: After reset the register reads 0x00 and `cfg_loaded` is 0.
- R3: Bits 6:0 take only the first write to offset zero after reset. Every later write leaves them unchanged.
- R4: Software cannot write bit 7. It reads 0 before the first write to offset zero and 1 from the first write on. `cfg_loaded` follows the same flag.
- R5: The tick repeats every (divider+1) oscillator cycles when the prescaler enable is 0, and every 8×(divider+1) cycles when it is 1. The largest ratio is 512.
- R6: `tick_en` is high for exactly one oscillator cycle per period whenever the ratio is above 1.
- R7: `tick_en` stays low while the register has not been written.
- R8: A write to any offset other than zero changes neither the register nor the flag. A read of any offset other than zero returns 0x00.
- R9: With an 8 MHz oscillator and the setting 0x45 (prescaler on, divider 5), the tick frequency lies between 150 kHz and 200 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` |
| tick_en | output | 1 | Single-cycle divided clock enable |
| cfg_loaded | output | 1 | High once the register has been written |

## Verification
Each kind of internal fault shows up at the ports in a known way:
- A configuration machine stuck in the wrong state, or accepting a second write, shows up on the very next read of offset zero as a wrong byte or a wrong flag bit.
- A miscounting prescaler or down-counter shows up within one tick period, as a tick interval that differs from the ratio in R5. For the largest setting that period is up to 512 cycles.
- A tick machine that leaves idle too early produces a pulse while `cfg_loaded` is still low.

The interval scoreboard measures the spacing between successive ticks against the ratio computed from the written byte. It also checks every setting with a fresh reset, so a stale count from an earlier setting cannot hide an error.

// File: rtl/ftd_pkg.sv
package ftd_pkg;
    localparam int REG_W    = 8;
    localparam int DIV_W    = 6;
    localparam int PRE_LOG2 = 3;
    localparam int FLAG_BIT = REG_W - 1;
    localparam int PRE_BIT  = REG_W - 2;

    typedef enum logic {
        CFG_BLANK  = 1'b0,
        CFG_LOCKED = 1'b1
    } cfg_state_t;

    typedef enum logic {
        TK_IDLE = 1'b0,
        TK_RUN  = 1'b1
    } tick_state_t;
endpackage

// File: rtl/ftd_cfg_reg.sv
module ftd_cfg_reg
    import ftd_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic          wr_pre8,
    input  logic [DW-1:0] wr_div,
    output logic          pre8,
    output logic [DW-1:0] div,
    output logic          loaded
);
    cfg_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: only the first hit leaves CFG_BLANK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_BLANK:  if (wr_hit) state_d = CFG_LOCKED;
            CFG_LOCKED: state_d = CFG_LOCKED;
        endcase
    end

    // field capture happens only on the BLANK -> LOCKED transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre8 <= 1'b0;
            div  <= '0;
        end else if (state_q == CFG_BLANK && wr_hit) begin
            pre8 <= wr_pre8;
            div  <= wr_div;
        end
    end

    always_comb begin
        loaded = (state_q == CFG_LOCKED);
    end
endmodule

// File: rtl/ftd_prescale.sv
module ftd_prescale
    import ftd_pkg::*;
#(
    parameter int LOG2 = PRE_LOG2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic enable8,
    output logic strobe
);
    generate
        if (LOG2 == 0) begin : g_none
            assign strobe = run;
        end else begin : g_cnt
            localparam logic [LOG2-1:0] LAST = '1;
            logic [LOG2-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (run) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign strobe = run && (!enable8 || cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ftd_tick_cnt.sv
module ftd_tick_cnt
    import ftd_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loaded,
    input  logic [DW-1:0] reload,
    input  logic          step,
    output logic          tick
);
    tick_state_t state_q, state_d;
    logic [DW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_IDLE: if (loaded) state_d = TK_RUN;
            TK_RUN:  state_d = TK_RUN;
        endcase
    end

    // down-counter: reloads on entry to TK_RUN and each time it hits zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                TK_IDLE: if (loaded) cnt_q <= reload;
                TK_RUN: begin
                    if (step) begin
                        if (cnt_q == '0) cnt_q <= reload;
                        else             cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            TK_IDLE: tick = 1'b0;
            TK_RUN:  tick = step && (cnt_q == '0);
        endcase
    end
endmodule

// File: rtl/flash_tick_div.sv
module flash_tick_div
    import ftd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              tick_en,
    output logic              cfg_loaded
);
    localparam logic [ADDR_W-1:0] CFG_OFFSET = '0;

    logic             sel_cfg;
    logic             cfg_pre8;
    logic [DIV_W-1:0] cfg_div;
    logic             pre_strobe;
    logic             unused_wd_flag;

    assign sel_cfg        = (bus_addr == CFG_OFFSET);
    assign unused_wd_flag = bus_wdata[FLAG_BIT];

    ftd_cfg_reg #(.DW(DIV_W)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (bus_wr && sel_cfg),
        .wr_pre8 (bus_wdata[PRE_BIT]),
        .wr_div  (bus_wdata[DIV_W-1:0]),
        .pre8    (cfg_pre8),
        .div     (cfg_div),
        .loaded  (cfg_loaded)
    );

    ftd_prescale #(.LOG2(PRE_LOG2)) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg_loaded),
        .enable8 (cfg_pre8),
        .strobe  (pre_strobe)
    );

    ftd_tick_cnt #(.DW(DIV_W)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .loaded (cfg_loaded),
        .reload (cfg_div),
        .step   (pre_strobe),
        .tick   (tick_en)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_cfg) begin
            bus_rdata[FLAG_BIT]    = cfg_loaded;
            bus_rdata[PRE_BIT]     = cfg_pre8;
            bus_rdata[DIV_W-1:0]   = cfg_div;
        end
    end
endmodule

// File: rtl/ftd_checker.sv
module ftd_checker #(
    parameter int ADDR_W = 4,
    parameter int DW     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic              tick_en,
    input logic              cfg_loaded,
    input logic              cfg_pre8,
    input logic [DW-1:0]     cfg_div
);
    // R7: no tick before configuration
    a_r7_no_tick_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_loaded |-> !tick_en);

    // R3: fields frozen once locked
    a_r3_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_loaded |=> ($stable(cfg_pre8) && $stable(cfg_div)));

    // R4: flag is sticky
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_loaded |=> cfg_loaded);

    // R4 / R8: flag rises only after a write to offset zero
    a_r4_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_loaded) |-> $past(bus_wr && bus_addr == '0));

    // R8: writes elsewhere leave the flag clear
    a_r8_other_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != '0 && !cfg_loaded) |=> !cfg_loaded);

    // R1: read of offset zero carries the flag in bit 7
    a_r1_flag_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[7] == cfg_loaded));

    // R6: pulse lasts one cycle when ratio above one
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && (cfg_pre8 || cfg_div != '0)) |=> !tick_en);
endmodule

bind flash_tick_div ftd_checker #(.ADDR_W(ADDR_W), .DW(ftd_pkg::DIV_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .tick_en    (tick_en),
    .cfg_loaded (cfg_loaded),
    .cfg_pre8   (cfg_pre8),
    .cfg_div    (cfg_div)
);

// File: tb/flash_tick_div_tb.sv
module flash_tick_div_tb_top;
    localparam int ADDR_W = 4;
    localparam int OSC_HZ = 8_000_000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              tick_en;
    logic              cfg_loaded;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // scoreboard state
    int exp_q[$];
    bit mon_en = 0;
    bit seen_first = 0;
    int gap = 0;
    int last_interval = 0;

    always #4 clk = ~clk;

    flash_tick_div #(.ADDR_W(ADDR_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tick_en    (tick_en),
        .cfg_loaded (cfg_loaded)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: measures spacing between ticks, compares to queued ratios
    always @(negedge clk) begin
        if (!mon_en) begin
            seen_first = 0;
            gap = 0;
        end else begin
            gap++;
            if (tick_en) begin
                if (seen_first && exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    last_interval = gap;
                    check("R5/R6 tick interval", gap, e);
                end
                seen_first = 1;
                gap = 0;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        mon_en = 0;
        rst_n = 0;
        bus_wr = 0;
        bus_addr = '0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        bus_addr = '0;
    endtask

    task automatic read_check(input string req, input logic [ADDR_W-1:0] a, input int exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_addr = '0;
    endtask

    // driver: locks a setting and queues the expected intervals
    task automatic run_setting(input logic [7:0] val, input int n);
        int ratio;
        ratio = (val[5:0] + 1) * (val[6] ? 8 : 1);
        do_reset();
        bus_write('0, val);
        for (int i = 0; i < n; i++) exp_q.push_back(ratio);
        mon_en = 1;
        while (exp_q.size() > 0) @(negedge clk);
        mon_en = 0;
    endtask

    initial begin
        int bad;
        do_reset();
        // R2: reset state
        read_check("R2 reset read", '0, 8'h00);
        check("R2 cfg_loaded after reset", cfg_loaded, 0);
        // R7: no tick while unconfigured
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick_en) bad++;
        end
        check("R7 ticks while unloaded", bad, 0);
        // R8: other offset write ignored, other offset read zero
        bus_write(4'h3, 8'hFF);
        read_check("R8 offset0 after other write", '0, 8'h00);
        check("R8 flag after other write", cfg_loaded, 0);
        read_check("R8 other offset read", 4'h3, 8'h00);
        // R1/R4: first write, bit 7 written as 0 but reads 1
        bus_write('0, 8'h45);
        read_check("R1/R4 readback", '0, 8'hC5);
        check("R4 cfg_loaded", cfg_loaded, 1);
        // R3: later writes ignored
        bus_write('0, 8'h3A);
        read_check("R3 second write ignored", '0, 8'hC5);
        bus_write('0, 8'h00);
        read_check("R3 third write ignored", '0, 8'hC5);

        // R5/R6/R9: prescaler on, divider 5 -> 48
        run_setting(8'h45, 3);
        check("R9 freq in window", ((OSC_HZ / last_interval) >= 150_000 &&
                                    (OSC_HZ / last_interval) <= 200_000) ? 1 : 0, 1);
        // R5: ratio 1, tick every cycle
        run_setting(8'h00, 3);
        // R5: prescaler off, divider 7
        run_setting(8'h07, 3);
        // R5: prescaler on, divider 0 -> 8
        run_setting(8'h40, 2);
        // R5: maximum ratio 512
        run_setting(8'h7F, 2);
        read_check("R1 max readback", '0, 8'hFF);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule